// File: doc/BRIEF.md
# Speculative Load Exception Deferral Unit

This block settles what happens to a speculative load once its exception conditions are known. It takes fourteen condition flags for one load together with the current control state: a master defer bit, the interruption-collection bit, the instruction-translation bit, the code page's defer-permit bit, seven per-category defer-control bits and a spontaneous-defer enable. From these it works out which conditions are deferred. It then gives one of three results: a not-a-thing (NaT) write to the target register, a fault carrying the code of the most urgent condition that was not deferred, or a normal completion.

The flags and control bits are captured on a valid strobe. The result appears on the outputs exactly one clock later and lasts for one cycle. Condition flag index `i` is also the fault code and the priority rank, and rank 0 is the most urgent. The ranks are: 0 register NaT consumption, 1 unimplemented address, 2 alternate TLB miss, 3 hashed-table data, 4 data TLB miss, 5 page not present, 6 NaT page, 7 key miss, 8 key permission, 9 access rights, 10 access bit, 11 debug, 12 unaligned, 13 unsupported reference.

Top module: `spec_defer_unit`

## Requirements
- R1: While rst_ni is low, and after it rises until the first strobe, nat_wr_o, fault_o and done_o are 0 and fault_code_o is 0.
- R2: A load strobed on valid_i at one rising edge gives its result during the next clock cycle only. No result output is high in a cycle that does not follow a strobe.
- R3: At most one of nat_wr_o, fault_o and done_o is high in any cycle.
- R4: When ed_i is 1, nat_wr_o is asserted whatever the flags and the other control bits are, including when no flag is set.
- R5: Flags 0, 1, 6 and 13 are always deferred. They never give a fault code.
- R6: When ic_i is 0, every flag is deferred.
- R7: Flags 2, 3 and 4 are deferred when it_i, page_ed_i and dcr_i[0] (miss) are all 1.
- R8: The following flags are deferred when it_i and page_ed_i are 1 and their own control bit is 1: flag 5 with dcr_i[1], flag 7 with dcr_i[2], flag 8 with dcr_i[3], flag 9 with dcr_i[4], flag 10 with dcr_i[5], flag 11 with dcr_i[6].
- R9: Flag 12 is deferred whenever it_i and page_ed_i are both 1.
- R10: When ic_i, it_i, page_ed_i and spont_en_i are all 1, every flag is deferred. When any of them is 0, spont_en_i has no effect.
- R11: When ed_i is 0 and some set flag is not deferred, fault_o is asserted and fault_code_o equals the lowest index among those flags.
- R12: When ed_i is 0 and no flag is set, done_o is asserted.
- R13: When ed_i is 0, at least one flag is set and every set flag is deferred, nat_wr_o is asserted and fault_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load strobe; captures the flags and control bits |
| cond_i | input | 14 | Condition flags; the index is the priority rank and fault code |
| ed_i | input | 1 | Master defer bit |
| ic_i | input | 1 | Interruption-collection bit |
| it_i | input | 1 | Instruction-translation bit |
| page_ed_i | input | 1 | Code page defer-permit bit |
| dcr_i | input | 7 | Per-category defer bits: miss, present, key miss, key perm, rights, access, debug |
| spont_en_i | input | 1 | Spontaneous-defer enable |
| nat_wr_o | output | 1 | Write NaT to the target register |
| fault_o | output | 1 | Fault raised |
| fault_code_o | output | 4 | Code of the faulting condition; 0 when no fault |
| done_o | output | 1 | Normal load completion |

## Verification
The assertions check on every cycle that the three outcomes exclude each other and appear only one cycle after a strobe. They also check that a set master defer bit gives a NaT write, that the always-deferred flags never give a fault code, and that a reported code belongs to a pending flag with no pending flag of lower index. The bench scenarios show the parts that depend on the control bits. These are each category's own qualifier, the collection-off override, the spontaneous-defer gating, and the choice between NaT and completion when nothing faults. The assertions cannot check these without repeating the decode.

// File: rtl/spec_defer_pkg.sv
package spec_defer_pkg;
  localparam int unsigned NUM_COND = 14;
  localparam int unsigned CODE_W   = $clog2(NUM_COND);
  localparam int unsigned NUM_CAT  = 7;

  // qualifier kinds
  localparam int Q_ALWAYS = -1;
  localparam int Q_PAGE   = -2;  // translation + page permit, no category bit

  // category bit indices in dcr
  localparam int K_MISS     = 0;
  localparam int K_PRESENT  = 1;
  localparam int K_KEYMISS  = 2;
  localparam int K_KEYPERM  = 3;
  localparam int K_RIGHTS   = 4;
  localparam int K_ACCESS   = 5;
  localparam int K_DEBUG    = 6;

  typedef struct packed {
    logic               ed;
    logic               ic;
    logic               it;
    logic               page_ed;
    logic               spont;
    logic [NUM_CAT-1:0] cat;
  } ctrl_t;

  function automatic int qual_of(input int c);
    case (c)
      0, 1, 6, 13: return Q_ALWAYS;
      2, 3, 4:     return K_MISS;
      5:           return K_PRESENT;
      7:           return K_KEYMISS;
      8:           return K_KEYPERM;
      9:           return K_RIGHTS;
      10:          return K_ACCESS;
      11:          return K_DEBUG;
      default:     return Q_PAGE;
    endcase
  endfunction
endpackage

// File: rtl/defer_qualify.sv
module defer_qualify
  import spec_defer_pkg::*;
(
  input  ctrl_t               ctrl_i,
  output logic [NUM_COND-1:0] defer_o
);
  logic page_ok;
  logic spont_ok;

  assign page_ok  = ctrl_i.it & ctrl_i.page_ed;
  assign spont_ok = ctrl_i.ic & page_ok & ctrl_i.spont;

  for (genvar i = 0; i < NUM_COND; i++) begin : g_cond
    localparam int Q = qual_of(i);
    if (Q == Q_ALWAYS) begin : g_always
      assign defer_o[i] = 1'b1;
    end else if (Q == Q_PAGE) begin : g_page
      assign defer_o[i] = ~ctrl_i.ic | page_ok | spont_ok;
    end else begin : g_cat
      assign defer_o[i] = ~ctrl_i.ic | (page_ok & ctrl_i.cat[Q]) | spont_ok;
    end
  end
endmodule

// File: rtl/defer_priority.sv
module defer_priority
  import spec_defer_pkg::*;
(
  input  logic [NUM_COND-1:0] pend_i,
  output logic                any_o,
  output logic [CODE_W-1:0]   code_o
);
  always_comb begin
    code_o = '0;
    for (int i = NUM_COND - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = CODE_W'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/spec_defer_unit.sv
module spec_defer_unit
  import spec_defer_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic                ed_i,
  input  logic                ic_i,
  input  logic                it_i,
  input  logic                page_ed_i,
  input  logic [NUM_CAT-1:0]  dcr_i,
  input  logic                spont_en_i,
  output logic                nat_wr_o,
  output logic                fault_o,
  output logic [CODE_W-1:0]   fault_code_o,
  output logic                done_o
);
  logic                valid_q;
  logic [NUM_COND-1:0] cond_q;
  ctrl_t               ctrl_q;
  logic [NUM_COND-1:0] defer;
  logic [NUM_COND-1:0] pend;
  logic                any_pend;
  logic [CODE_W-1:0]   sel_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cond_q  <= '0;
      ctrl_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        cond_q  <= cond_i;
        ctrl_q  <= '{ed: ed_i, ic: ic_i, it: it_i, page_ed: page_ed_i,
                     spont: spont_en_i, cat: dcr_i};
      end
    end
  end

  defer_qualify u_qual (
    .ctrl_i (ctrl_q),
    .defer_o(defer)
  );

  assign pend = cond_q & ~defer;

  defer_priority u_prio (
    .pend_i(pend),
    .any_o (any_pend),
    .code_o(sel_code)
  );

  assign fault_o      = valid_q & ~ctrl_q.ed & any_pend;
  assign nat_wr_o     = valid_q & (ctrl_q.ed | ((|cond_q) & ~any_pend));
  assign done_o       = valid_q & ~ctrl_q.ed & ~(|cond_q);
  assign fault_code_o = fault_o ? sel_code : '0;

  a_r3_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({nat_wr_o, fault_o, done_o}) <= 1);

  a_r2_only_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> !(nat_wr_o | fault_o | done_o));

  a_r2_result_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) |-> (nat_wr_o | fault_o | done_o));

  a_r4_master_nat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && ed_i) |-> nat_wr_o);

  a_r5_never_always_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !(fault_code_o inside {4'd0, 4'd1, 4'd6, 4'd13}));

  a_r11_code_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (pend[fault_code_o] && ((pend & ((14'd1 << fault_code_o) - 14'd1)) == '0)));

  a_r1_code_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> fault_code_o == '0);
endmodule

// File: tb/sim_spec_defer_unit.sv
`timescale 1ns/1ps
module sim_spec_defer_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [13:0] cond_i = '0;
  logic        ed_i = 1'b0, ic_i = 1'b0, it_i = 1'b0, page_ed_i = 1'b0, spont_en_i = 1'b0;
  logic [6:0]  dcr_i = '0;
  logic        nat_wr_o, fault_o, done_o;
  logic [3:0]  fault_code_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  spec_defer_unit u0 (.*);

  localparam int NAT = 0, FLT = 1, DONE = 2;

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got nat/flt/done/code=%b expected %b", req, act, exp);
    end
  endtask

  // ctl = {ed, ic, it, page_ed, spont}
  task automatic run(input string req, input logic [13:0] c, input logic [4:0] ctl,
                     input logic [6:0] d, input int kind, input int code);
    logic [6:0] exp;
    @(negedge clk_i);
    cond_i = c; {ed_i, ic_i, it_i, page_ed_i, spont_en_i} = ctl; dcr_i = d; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    exp = {kind == NAT, kind == FLT, kind == DONE, (kind == FLT) ? 4'(code) : 4'd0};
    check(req, {nat_wr_o, fault_o, done_o, fault_code_o}, exp);
    @(negedge clk_i);
    check("R2", {nat_wr_o, fault_o, done_o, fault_code_o}, 7'b0);
  endtask

  task automatic t_reset;
    check("R1", {nat_wr_o, fault_o, done_o, fault_code_o}, 7'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1", {nat_wr_o, fault_o, done_o, fault_code_o}, 7'b0);
  endtask

  task automatic t_master;
    run("R4", 14'h0000, 5'b10000, 7'h00, NAT, 0);
    run("R4", 14'h0004, 5'b11000, 7'h00, NAT, 0);
    run("R4", 14'h3FFF, 5'b11111, 7'h7F, NAT, 0);
  endtask

  task automatic t_always;
    run("R5", 14'h0001, 5'b01000, 7'h00, NAT, 0);
    run("R5", 14'h2042, 5'b01000, 7'h00, NAT, 0);
    run("R5", 14'h0041 | 14'h0080, 5'b01000, 7'h00, FLT, 7);
  endtask

  task automatic t_collect_off;
    run("R6", 14'h3FFF, 5'b00000, 7'h00, NAT, 0);
    run("R6", 14'h0004, 5'b00000, 7'h00, NAT, 0);
    run("R6", 14'h0000, 5'b00000, 7'h00, DONE, 0);
  endtask

  task automatic t_tlb;
    run("R7", 14'h001C, 5'b01110, 7'h01, NAT, 0);
    run("R7", 14'h0008, 5'b01110, 7'h7E, FLT, 3);
    run("R7", 14'h0010, 5'b01010, 7'h01, FLT, 4);
    run("R7", 14'h0024, 5'b01110, 7'h01, FLT, 5);
  endtask

  task automatic t_category;
    int f[6] = '{5, 7, 8, 9, 10, 11};
    for (int k = 0; k < 6; k++) begin
      run("R8", 14'(1) << f[k], 5'b01110, 7'(1) << (k + 1), NAT, 0);
      run("R8", 14'(1) << f[k], 5'b01110, ~(7'(1) << (k + 1)), FLT, f[k]);
    end
    run("R8", 14'h0020, 5'b01100, 7'h7F, FLT, 5);
  endtask

  task automatic t_unaligned;
    run("R9", 14'h1000, 5'b01110, 7'h00, NAT, 0);
    run("R9", 14'h1000, 5'b01010, 7'h7F, FLT, 12);
    run("R9", 14'h3000, 5'b01100, 7'h00, FLT, 12);
  endtask

  task automatic t_spont;
    run("R10", 14'h0804, 5'b01111, 7'h00, NAT, 0);
    run("R10", 14'h0800, 5'b01011, 7'h00, FLT, 11);
    run("R10", 14'h0800, 5'b01101, 7'h00, FLT, 11);
  endtask

  task automatic t_priority;
    run("R11", 14'h3FFC, 5'b01000, 7'h00, FLT, 2);
    run("R11", 14'h0F80, 5'b01110, 7'h04, FLT, 8);
    run("R11", 14'h1E00, 5'b01000, 7'h00, FLT, 9);
  endtask

  task automatic t_complete;
    run("R12", 14'h0000, 5'b01110, 7'h7F, DONE, 0);
    run("R13", 14'h0084, 5'b01110, 7'h05, NAT, 0);
  endtask

  task automatic t_exclusive;
    // R3: idle with no strobe keeps every outcome low
    repeat (3) @(negedge clk_i);
    check("R3", {nat_wr_o, fault_o, done_o, fault_code_o}, 7'b0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_master();
    t_always();
    t_collect_off();
    t_tlb();
    t_category();
    t_unaligned();
    t_spont();
    t_priority();
    t_complete();
    t_exclusive();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule